// File: doc/BRIEF.md
# ADC Hardware Trigger Selector

This block creates the conversion-start request for a single converter unit. It watches a group of hardware event inputs: an asynchronous external trigger pin, four event pulses for each PWM channel, timer match pulses, a capture event and the done flags of both converter units. A 4-bit source code picks one of these inputs. For the external pin, a 2-bit mode picks which edge counts. For a PWM channel, a 2-bit event code picks which of its four event pulses counts.

A hardware hit only counts when the unit's hardware-trigger enable is set. A counted hit then waits for a programmable number of system clocks, equal to the delay field times four. After that wait the block emits a single-cycle start pulse. A software start request skips both the enable and the delay and gives a start pulse on the next cycle. All configuration arrives on plain input ports, which a register block elsewhere drives.

Top module: `adc_trig_sel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls with no stimulus, `start_o` is 0.
- R2: With `hw_en`=1 and `dly_units`=0, each source code gives a `start_o` pulse in the cycle after the selected input's rising edge. The codes are: 0 external pin, 1..6 PWM channels 0..5, 7 and 8 timer match 0 and 1, 9 capture event, 10 and 11 done flags of units 0 and 1.
- R3: For a PWM source, `pwm_evt_sel` picks the event. Code 0 is `pwm_fall`, 1 is `pwm_mid`, 2 is `pwm_rise` and 3 is `pwm_prd`. A pulse on any other event vector of that channel gives no start.
- R4: The external pin passes through two synchronizer flops and is then edge-checked. `pin_edge_sel` 0 selects rising, 1 falling and 2 either edge. A pin change driven in cycle c gives a start in cycle c+3 when the delay is 0. An edge of the wrong polarity gives nothing.
- R5: Source codes 12 to 15 never give a hardware start, whatever the inputs do. With source 0, `pin_edge_sel`=3 (reserved) also never gives a start.
- R6: With `hw_en`=0, no hardware event gives a start.
- R7: With `dly_units`=N>0, a hardware hit seen in cycle c gives a start in cycle c+1+4N. This holds up to N=255.
- R8: A `sw_start` pulse in cycle c gives a start in cycle c+1, whatever `hw_en` and `dly_units` are. This also holds while a delayed hardware start is pending, and that pending start still fires on time.
- R9: A hardware hit that arrives while a delay is pending is dropped. It does not restart the count and gives no second pulse. A hit after the pending start has fired is accepted again.
- R10: The block acts on rising edges of internal event inputs. A done flag held high for many cycles gives exactly one single-cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Hardware-trigger enable |
| src_sel | input | 4 | Hardware source code |
| pin_edge_sel | input | 2 | External pin edge mode |
| pwm_evt_sel | input | 2 | PWM event type code |
| dly_units | input | 8 | Delay in units of four clocks |
| sw_start | input | 1 | Software start request |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| pwm_fall | input | 6 | PWM output falling-edge event pulses |
| pwm_mid | input | 6 | PWM counter centre event pulses |
| pwm_rise | input | 6 | PWM output rising-edge event pulses |
| pwm_prd | input | 6 | PWM period event pulses |
| tmr_match | input | 2 | Timer match pulses |
| cap_evt | input | 1 | Capture event |
| done_flag | input | 2 | Converter done flags, unit 0 and unit 1 |
| start_o | output | 1 | Conversion start pulse |

## Verification
The bench builds the block with its default parameters: six PWM channels, two timers, two done flags, an 8-bit delay field with a scale of four, and two synchronizer stages. With these values all twelve live source codes and all four unused codes can be reached from the ports. The full delay range is also reachable, up to 1020 cycles, so the bench can check the zero-delay path, short delays and the largest delay. It can also overlap a software start and a second hardware hit with a pending count.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    // Pin edge mode.
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_RSVD = 2'd3
    } pin_edge_e;

    // PWM event kind.
    typedef enum logic [1:0] {
        PEV_FALL = 2'd0,
        PEV_MID  = 2'd1,
        PEV_RISE = 2'd2,
        PEV_PRD  = 2'd3
    } pwm_evt_e;

    // Edges found on a synchronized level.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    // Qualify the pin edges against the selected mode; the reserved mode never hits.
    function automatic logic pin_match(edge_pair_t e, pin_edge_e m);
        case (m)
            EDGE_RISE: return e.rise;
            EDGE_FALL: return e.fall;
            EDGE_BOTH: return e.rise | e.fall;
            default:   return 1'b0;
        endcase
    endfunction

    // Pick one PWM event kind out of the four.
    function automatic logic pwm_pick(logic f, logic m, logic r, logic p, pwm_evt_e s);
        case (s)
            PEV_FALL: return f;
            PEV_MID:  return m;
            PEV_RISE: return r;
            default:  return p;
        endcase
    endfunction

endpackage

// File: rtl/trig_pin_sync.sv
module trig_pin_sync
    import adc_trig_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    output edge_pair_t edg_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign edg_o.rise = sync_q[STAGES-1] & ~last_q;
    assign edg_o.fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/trig_evt_edge.sv
module trig_evt_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= in_i;
    end

    assign rise_o = in_i & ~prev_q;
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
    import adc_trig_pkg::*;
#(
    parameter int NUM_PWM  = 6,
    parameter int NUM_TMR  = 2,
    parameter int NUM_DONE = 2,
    parameter int SEL_W    = 4
) (
    input  edge_pair_t           pin_edges,
    input  pin_edge_e            pin_mode,
    input  pwm_evt_e             pwm_kind,
    input  logic [SEL_W-1:0]     src_sel,
    input  logic [NUM_PWM-1:0]   pwm_fall_r,
    input  logic [NUM_PWM-1:0]   pwm_mid_r,
    input  logic [NUM_PWM-1:0]   pwm_rise_r,
    input  logic [NUM_PWM-1:0]   pwm_prd_r,
    input  logic [NUM_TMR-1:0]   tmr_r,
    input  logic                 cap_r,
    input  logic [NUM_DONE-1:0]  done_r,
    output logic                 hit_o
);
    localparam int SRC_PIN   = 0;
    localparam int SRC_PWM0  = 1;
    localparam int SRC_TMR0  = SRC_PWM0 + NUM_PWM;
    localparam int SRC_CAP   = SRC_TMR0 + NUM_TMR;
    localparam int SRC_DONE0 = SRC_CAP + 1;
    localparam int NUM_SRC   = SRC_DONE0 + NUM_DONE;
    localparam int NUM_CODE  = 1 << SEL_W;

    logic [NUM_PWM-1:0]  pwm_ev;
    logic [NUM_SRC-1:0]  evt;
    logic [NUM_CODE-1:0] evt_pad;

    always_comb begin
        for (int i = 0; i < NUM_PWM; i++) begin
            pwm_ev[i] = pwm_pick(pwm_fall_r[i], pwm_mid_r[i], pwm_rise_r[i],
                                 pwm_prd_r[i], pwm_kind);
        end
    end

    assign evt[SRC_PIN] = pin_match(pin_edges, pin_mode);
    assign evt[SRC_CAP] = cap_r;

    for (genvar g = 0; g < NUM_PWM; g++) begin : g_pwm
        assign evt[SRC_PWM0 + g] = pwm_ev[g];
    end
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        assign evt[SRC_TMR0 + g] = tmr_r[g];
    end
    for (genvar g = 0; g < NUM_DONE; g++) begin : g_done
        assign evt[SRC_DONE0 + g] = done_r[g];
    end

    // Codes past the last live source read as a constant zero.
    for (genvar g = 0; g < NUM_CODE; g++) begin : g_pad
        if (g < NUM_SRC) begin : g_live
            assign evt_pad[g] = evt[g];
        end else begin : g_dead
            assign evt_pad[g] = 1'b0;
        end
    end

    assign hit_o = evt_pad[src_sel];
endmodule

// File: rtl/trig_delay.sv
module trig_delay #(
    parameter int DLY_W     = 8,
    parameter int DLY_SCALE = 4,
    parameter int CNT_W     = DLY_W + $clog2(DLY_SCALE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_i,
    input  logic             sw_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             start_o,
    output logic             pend_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] load;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_q;

    assign load = CNT_W'(dly_i) * CNT_W'(DLY_SCALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= sw_i;
            if (pend_q) begin
                // A pending count ignores fresh hardware hits.
                if (cnt_q == CNT_W'(1)) begin
                    pend_q  <= 1'b0;
                    cnt_q   <= '0;
                    start_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end else if (hit_i) begin
                if (dly_i == '0) begin
                    start_q <= 1'b1;
                end else begin
                    pend_q <= 1'b1;
                    cnt_q  <= load;
                end
            end
        end
    end

    assign start_o = start_q;
    assign pend_o  = pend_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_trig_pkg::*;
#(
    parameter int NUM_PWM     = 6,
    parameter int NUM_TMR     = 2,
    parameter int NUM_DONE    = 2,
    parameter int DLY_W       = 8,
    parameter int DLY_SCALE   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_en,
    input  logic [SEL_W-1:0]    src_sel,
    input  logic [1:0]          pin_edge_sel,
    input  logic [1:0]          pwm_evt_sel,
    input  logic [DLY_W-1:0]    dly_units,
    input  logic                sw_start,
    input  logic                ext_pin,
    input  logic [NUM_PWM-1:0]  pwm_fall,
    input  logic [NUM_PWM-1:0]  pwm_mid,
    input  logic [NUM_PWM-1:0]  pwm_rise,
    input  logic [NUM_PWM-1:0]  pwm_prd,
    input  logic [NUM_TMR-1:0]  tmr_match,
    input  logic                cap_evt,
    input  logic [NUM_DONE-1:0] done_flag,
    output logic                start_o
);
    localparam int CNT_W = DLY_W + $clog2(DLY_SCALE);
    localparam int EV_W  = 4 * NUM_PWM + NUM_TMR + 1 + NUM_DONE;

    edge_pair_t          pin_edges;
    logic [EV_W-1:0]     ev_raw;
    logic [EV_W-1:0]     ev_rise;
    logic                mux_hit;
    logic                hw_hit;
    logic                dly_pend;
    logic [CNT_W-1:0]    dly_cnt;

    trig_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk   (clk),
        .rst   (rst),
        .pin_i (ext_pin),
        .edg_o (pin_edges)
    );

    assign ev_raw = {done_flag, cap_evt, tmr_match, pwm_prd, pwm_rise, pwm_mid, pwm_fall};

    trig_evt_edge #(.W(EV_W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .in_i   (ev_raw),
        .rise_o (ev_rise)
    );

    trig_src_mux #(
        .NUM_PWM  (NUM_PWM),
        .NUM_TMR  (NUM_TMR),
        .NUM_DONE (NUM_DONE),
        .SEL_W    (SEL_W)
    ) u_mux (
        .pin_edges  (pin_edges),
        .pin_mode   (pin_edge_e'(pin_edge_sel)),
        .pwm_kind   (pwm_evt_e'(pwm_evt_sel)),
        .src_sel    (src_sel),
        .pwm_fall_r (ev_rise[0 +: NUM_PWM]),
        .pwm_mid_r  (ev_rise[NUM_PWM +: NUM_PWM]),
        .pwm_rise_r (ev_rise[2*NUM_PWM +: NUM_PWM]),
        .pwm_prd_r  (ev_rise[3*NUM_PWM +: NUM_PWM]),
        .tmr_r      (ev_rise[4*NUM_PWM +: NUM_TMR]),
        .cap_r      (ev_rise[4*NUM_PWM + NUM_TMR]),
        .done_r     (ev_rise[4*NUM_PWM + NUM_TMR + 1 +: NUM_DONE]),
        .hit_o      (mux_hit)
    );

    assign hw_hit = hw_en & mux_hit;

    trig_delay #(
        .DLY_W     (DLY_W),
        .DLY_SCALE (DLY_SCALE),
        .CNT_W     (CNT_W)
    ) u_dly (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hw_hit),
        .sw_i    (sw_start),
        .dly_i   (dly_units),
        .start_o (start_o),
        .pend_o  (dly_pend),
        .cnt_o   (dly_cnt)
    );
endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk #(
    parameter int DLY_W     = 8,
    parameter int DLY_SCALE = 4,
    parameter int CNT_W     = 10,
    parameter int SEL_W     = 4,
    parameter int NUM_SRC   = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             hw_en,
    input logic             sw_start,
    input logic [SEL_W-1:0] src_sel,
    input logic [DLY_W-1:0] dly_units,
    input logic             start_o,
    input logic             hit,
    input logic             pend,
    input logic [CNT_W-1:0] cnt
);
    assert_sw_next_R8: assert property (@(posedge clk) disable iff (rst)
        sw_start |=> start_o);

    assert_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
        (pend && cnt != CNT_W'(1)) |=> (pend && cnt == $past(cnt) - CNT_W'(1)));

    assert_hw_off_R6: assert property (@(posedge clk) disable iff (rst)
        (!hw_en && !pend && !sw_start) |=> !start_o);

    assert_dead_code_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(src_sel) >= NUM_SRC && !pend && !sw_start) |=> !start_o);

    assert_expire_R7: assert property (@(posedge clk) disable iff (rst)
        (pend && cnt == CNT_W'(1)) |=> start_o);

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        (!pend && hit && dly_units != '0) |=>
        (pend && cnt == CNT_W'($past(dly_units)) * CNT_W'(DLY_SCALE)));

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !start_o);
endmodule

bind adc_trig_sel adc_trig_sel_chk #(
    .DLY_W     (DLY_W),
    .DLY_SCALE (DLY_SCALE),
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W),
    .NUM_SRC   (1 + NUM_PWM + NUM_TMR + 1 + NUM_DONE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hw_en     (hw_en),
    .sw_start  (sw_start),
    .src_sel   (src_sel),
    .dly_units (dly_units),
    .start_o   (start_o),
    .hit       (hw_hit),
    .pend      (dly_pend),
    .cnt       (dly_cnt)
);

// File: tb/adc_trig_sel_test.sv
`timescale 1ns/1ps
module adc_trig_sel_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       hw_en;
    logic [3:0] src_sel;
    logic [1:0] pin_edge_sel;
    logic [1:0] pwm_evt_sel;
    logic [7:0] dly_units;
    logic       sw_start;
    logic       ext_pin;
    logic [5:0] pwm_fall, pwm_mid, pwm_rise, pwm_prd;
    logic [1:0] tmr_match;
    logic       cap_evt;
    logic [1:0] done_flag;
    logic       start_o;

    always #2 clk = ~clk;

    adc_trig_sel uut (
        .clk(clk), .rst(rst), .hw_en(hw_en), .src_sel(src_sel),
        .pin_edge_sel(pin_edge_sel), .pwm_evt_sel(pwm_evt_sel),
        .dly_units(dly_units), .sw_start(sw_start), .ext_pin(ext_pin),
        .pwm_fall(pwm_fall), .pwm_mid(pwm_mid), .pwm_rise(pwm_rise),
        .pwm_prd(pwm_prd), .tmr_match(tmr_match), .cap_evt(cap_evt),
        .done_flag(done_flag), .start_o(start_o)
    );

    typedef struct {
        int    at;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done_run = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every start pulse must match a queued expectation for this cycle.
    always @(negedge clk) begin
        if (!rst && start_o) begin
            int idx;
            idx = -1;
            foreach (exp_q[i]) if (idx < 0 && exp_q[i].at == cyc) idx = i;
            checks++;
            if (idx < 0) begin
                fails++;
                $display("FAIL %s: start_o=1 at cycle %0d, expected 0 (no start queued)", cur_req, cyc);
            end else begin
                exp_q.delete(idx);
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int at, input string req);
        exp_t e;
        e.at  = at;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic clear_events();
        pwm_fall = '0; pwm_mid = '0; pwm_rise = '0; pwm_prd = '0;
        tmr_match = '0; cap_evt = 1'b0; done_flag = '0;
    endtask

    // Pulse the input of one source code for one cycle; ev picks the PWM vector.
    task automatic hit_src(input int code, input int ev, input bit want, input string req);
        cur_req = req;
        if (want) expect_at(cyc + 1 + 4 * int'(dly_units), req);
        if (code >= 1 && code <= 6) begin
            case (ev)
                0: pwm_fall[code-1] = 1'b1;
                1: pwm_mid[code-1]  = 1'b1;
                2: pwm_rise[code-1] = 1'b1;
                default: pwm_prd[code-1] = 1'b1;
            endcase
        end else if (code == 7 || code == 8) begin
            tmr_match[code-7] = 1'b1;
        end else if (code == 9) begin
            cap_evt = 1'b1;
        end else if (code == 10 || code == 11) begin
            done_flag[code-10] = 1'b1;
        end
        tick();
        clear_events();
    endtask

    task automatic pulse_all(input string req);
        cur_req = req;
        pwm_fall = '1; pwm_mid = '1; pwm_rise = '1; pwm_prd = '1;
        tmr_match = '1; cap_evt = 1'b1; done_flag = '1;
        tick();
        clear_events();
    endtask

    task automatic set_pin(input logic v, input bit want, input string req);
        cur_req = req;
        if (want) expect_at(cyc + 3 + 4 * int'(dly_units), req);
        ext_pin = v;
        tick(5);
    endtask

    task automatic sw_pulse(input string req);
        cur_req = req;
        expect_at(cyc + 1, req);
        sw_start = 1'b1;
        tick();
        sw_start = 1'b0;
    endtask

    // Wait out the longest delay, then every queued start must have been seen.
    task automatic drain(input string req);
        tick(4 * int'(dly_units) + 10);
        checks++;
        if (exp_q.size() != 0) begin
            foreach (exp_q[i]) begin
                fails++;
                $display("FAIL %s: start_o=0 at cycle %0d, expected 1 (%0d still pending)",
                         exp_q[i].req, exp_q[i].at, exp_q.size());
            end
            exp_q.delete();
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run active=1, expected 0 after 200000 cycles");
        finish_run();
    end

    initial begin
        rst = 1'b1; hw_en = 1'b0; src_sel = '0; pin_edge_sel = '0;
        pwm_evt_sel = '0; dly_units = '0; sw_start = 1'b0; ext_pin = 1'b0;
        clear_events();
        tick(3);
        checks++;
        if (start_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: start_o=%b during reset, expected 0", start_o);
        end
        rst = 1'b0;
        tick();
        checks++;
        if (start_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: start_o=%b after reset, expected 0", start_o);
        end

        // R2 / R3: each PWM channel with a rotating event kind.
        hw_en = 1'b1;
        for (int code = 1; code <= 6; code++) begin
            src_sel = 4'(code);
            pwm_evt_sel = 2'((code - 1) % 4);
            hit_src(code, (code - 1) % 4, 1'b1, "R2");
            tick(3);
        end
        src_sel = 4'd2;
        pwm_evt_sel = 2'd3;
        hit_src(2, 0, 1'b0, "R3");
        tick(3);
        hit_src(2, 1, 1'b0, "R3");
        tick(3);
        hit_src(2, 3, 1'b1, "R3");
        drain("R3");

        // R2: timers, capture, unit-1 done.
        for (int code = 7; code <= 11; code++) begin
            if (code != 10) begin
                src_sel = 4'(code);
                hit_src(code, 0, 1'b1, "R2");
                tick(3);
            end
        end
        drain("R2");

        // R10: a held done flag gives one start only.
        src_sel = 4'd10;
        cur_req = "R10";
        expect_at(cyc + 1, "R10");
        done_flag[0] = 1'b1;
        tick(12);
        done_flag[0] = 1'b0;
        drain("R10");

        // R5: unused codes and the reserved pin mode.
        for (int code = 12; code <= 15; code++) begin
            src_sel = 4'(code);
            pulse_all("R5");
            tick(2);
        end
        drain("R5");
        src_sel = 4'd0;
        pin_edge_sel = 2'd3;
        set_pin(1'b1, 1'b0, "R5");
        set_pin(1'b0, 1'b0, "R5");
        drain("R5");

        // R6: hardware enable off.
        hw_en = 1'b0;
        src_sel = 4'd7;
        hit_src(7, 0, 1'b0, "R6");
        src_sel = 4'd0;
        pin_edge_sel = 2'd2;
        set_pin(1'b1, 1'b0, "R6");
        set_pin(1'b0, 1'b0, "R6");
        drain("R6");
        hw_en = 1'b1;

        // R4: pin edge modes through the synchronizer.
        pin_edge_sel = 2'd0;
        set_pin(1'b1, 1'b1, "R4");
        set_pin(1'b0, 1'b0, "R4");
        pin_edge_sel = 2'd1;
        set_pin(1'b1, 1'b0, "R4");
        set_pin(1'b0, 1'b1, "R4");
        pin_edge_sel = 2'd2;
        set_pin(1'b1, 1'b1, "R4");
        set_pin(1'b0, 1'b1, "R4");
        drain("R4");

        // R7: delays of several lengths.
        src_sel = 4'd8;
        dly_units = 8'd1;
        hit_src(8, 0, 1'b1, "R7");
        drain("R7");
        dly_units = 8'd3;
        hit_src(8, 0, 1'b1, "R7");
        drain("R7");
        dly_units = 8'd255;
        hit_src(8, 0, 1'b1, "R7");
        drain("R7");
        src_sel = 4'd0;
        pin_edge_sel = 2'd0;
        dly_units = 8'd2;
        set_pin(1'b1, 1'b1, "R7");
        drain("R7");
        set_pin(1'b0, 1'b0, "R7");
        drain("R7");

        // R9: hit during a pending count is dropped.
        src_sel = 4'd9;
        dly_units = 8'd2;
        hit_src(9, 0, 1'b1, "R9");
        tick(2);
        hit_src(9, 0, 1'b0, "R9");
        drain("R9");
        hit_src(9, 0, 1'b1, "R9");
        drain("R9");

        // R8: software start ignores enable and delay.
        hw_en = 1'b0;
        dly_units = 8'd5;
        sw_pulse("R8");
        drain("R8");
        hw_en = 1'b1;
        src_sel = 4'd7;
        dly_units = 8'd3;
        hit_src(7, 0, 1'b1, "R8");
        tick(2);
        sw_pulse("R8");
        drain("R8");

        finish_run();
    end
endmodule